// File: doc/BRIEF.md
# Configuration EEPROM Image Builder and Checker

This block holds a 128-byte image intended for a serial configuration EEPROM and can either rebuild that image from its factory defaults or check an image that is already stored. In build mode, a start pulse loads the default contents in one cycle. The block then reads the image as little-endian 16-bit words, one word per clock, and sums the first 63 words modulo 2^16. It writes a two-byte check value into the top of the image, chosen so that all 64 words add up to the signature 0x1234.

In verify mode the same accumulator walks all 64 words, including the stored check value. It then reports whether the total equals the signature. While idle, the image can be loaded or patched through a byte write port. A combinational byte read port returns any location at any time, so the finished image can be copied to the serial device by a separate engine.

Top module: `cfgimg_image_gen`

## Requirements
- R1: A build run loads these defaults. Bytes 0..31 hold 0x57 at even offsets and 0x00 at odd offsets. Byte 64 holds the adapter bus ID (default 7). Byte 67 holds the tagged-command count (default 4). Byte 68 holds the option flags, with bit 0 = boot hotkey, bit 1 = boot from optical disk, bit 2 = BIOS disk service and bit 3 = automatic ID assignment (default 0x07). Byte 69 holds the boot target ID (default 0) and byte 70 the boot LUN (default 0). Every other byte below 126 is 0x00.
- R2: A build run sums word i = byte[2i] + 256*byte[2i+1] for i = 0..62, modulo 2^16. It then stores C = 0x1234 - sum, with the low byte of C at offset 126 and the high byte at offset 127.
- R3: A verify run sums all 64 words modulo 2^16, wrapping on overflow. valid_o is 1 after the run only when that sum equals 0x1234.
- R4: In both modes, done_o is a one-cycle pulse that rises exactly 65 clock cycles after the edge that samples start_i. busy_o is high from that sampling edge until the edge that raises done_o, and the two are never high together.
- R5: A start_i pulse while busy_o is high is ignored. The run in progress finishes on time, and no second run follows.
- R6: A byte write (wr_en_i) while idle updates the addressed byte at the next clock edge. A write while busy_o is high is ignored.
- R7: rd_data_o combinationally shows the byte at rd_addr_i, including during a run.
- R8: After reset busy_o, done_o and valid_o are 0 and every image byte reads 0x00.
- R9: valid_o clears when a run starts and holds its value until the next run. A build run leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run (sampled while idle) |
| verify_i | input | 1 | Run mode sampled with start: 0 build, 1 verify |
| wr_en_i | input | 1 | Byte write strobe (idle only) |
| wr_addr_i | input | 7 | Byte write address |
| wr_data_i | input | 8 | Byte write data |
| rd_addr_i | input | 7 | Byte read address |
| rd_data_o | output | 8 | Byte read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | Result of the last verify run |

## Verification
The bench loads an image whose word sum wraps past 2^16 many times. A design that saturates, or keeps more than 16 bits, would then reject a correct image. It changes one bit of the stored check value and expects rejection, which catches a verify that stops at word 62. It reads back all 128 bytes after each build, so an off-by-one in the word index, swapped check bytes, or a subtraction in the wrong direction each show up as a mismatch. It also writes and restarts in the middle of a run, expecting an unchanged image and a single on-time done pulse. A design without the busy guard would corrupt the sum or start a second run.

// File: rtl/cfgimg_pkg.sv
package cfgimg_pkg;

  localparam int unsigned IMG_BYTES = 128;
  localparam int unsigned ADDR_W    = $clog2(IMG_BYTES);
  localparam int unsigned WORDS     = IMG_BYTES / 2;
  localparam int unsigned WIDX_W    = $clog2(WORDS);

  // layout positions that a reader of the image decodes
  localparam int unsigned PAT_BYTES    = 32;
  localparam logic [7:0]  PAT_EVEN     = 8'h57;
  localparam int unsigned OFS_SCSI_ID  = 64;
  localparam int unsigned OFS_TAG_CNT  = 67;
  localparam int unsigned OFS_OPTIONS  = 68;
  localparam int unsigned OFS_BOOT_ID  = 69;
  localparam int unsigned OFS_BOOT_LUN = 70;
  localparam int unsigned OFS_CHK_LO   = IMG_BYTES - 2;
  localparam int unsigned OFS_CHK_HI   = IMG_BYTES - 1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_SUM    = 2'd2,
    ST_FINISH = 2'd3
  } seq_state_t;

endpackage

// File: rtl/cfgimg_store.sv
module cfgimg_store
  import cfgimg_pkg::*;
#(
  parameter logic [7:0] P_SCSI_ID   = 8'd7,
  parameter logic [7:0] P_TAG_CNT   = 8'd4,
  parameter logic [3:0] P_OPT_FLAGS = 4'b0111,
  parameter logic [7:0] P_BOOT_ID   = 8'd0,
  parameter logic [7:0] P_BOOT_LUN  = 8'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic              chk_en,
  input  logic [15:0]       chk_val,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [WIDX_W-1:0] word_idx,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [15:0]       word_o
);

  localparam int unsigned FLAT_W = IMG_BYTES * 8;

  logic [FLAT_W-1:0] img_flat;

  function automatic logic [7:0] dflt_byte(input int unsigned a);
    logic [7:0] v;
    v = 8'h00;
    if (a < PAT_BYTES) begin
      v = (a % 2 == 0) ? PAT_EVEN : 8'h00;
    end else if (a == OFS_SCSI_ID) begin
      v = P_SCSI_ID;
    end else if (a == OFS_TAG_CNT) begin
      v = P_TAG_CNT;
    end else if (a == OFS_OPTIONS) begin
      v = {4'b0000, P_OPT_FLAGS};
    end else if (a == OFS_BOOT_ID) begin
      v = P_BOOT_ID;
    end else if (a == OFS_BOOT_LUN) begin
      v = P_BOOT_LUN;
    end
    return v;
  endfunction

  for (genvar g = 0; g < IMG_BYTES; g++) begin : g_byte
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
    localparam logic [7:0]        MY_DFLT = dflt_byte(g);
    localparam bit                IS_LO   = (g == OFS_CHK_LO);
    localparam bit                IS_HI   = (g == OFS_CHK_HI);

    logic [7:0] byte_q;
    logic [7:0] byte_d;
    logic       byte_ce;
    logic       wr_hit;
    logic       chk_hit;

    assign wr_hit  = wr_en && (wr_addr == MY_ADDR);
    assign chk_hit = chk_en && (IS_LO || IS_HI);

    always_comb begin
      byte_d  = byte_q;
      byte_ce = 1'b0;
      if (fill_en) begin
        byte_d  = MY_DFLT;
        byte_ce = 1'b1;
      end else if (chk_hit) begin
        byte_d  = IS_HI ? chk_val[15:8] : chk_val[7:0];
        byte_ce = 1'b1;
      end else if (wr_hit) begin
        byte_d  = wr_data;
        byte_ce = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= 8'h00;
      end else if (byte_ce) begin
        byte_q <= byte_d;
      end
    end

    assign img_flat[g*8 +: 8] = byte_q;
  end

  assign rd_data = img_flat[{rd_addr, 3'b000} +: 8];
  assign word_o  = img_flat[{word_idx, 4'b0000} +: 16];

endmodule

// File: rtl/cfgimg_accum.sv
module cfgimg_accum #(
  parameter int unsigned SUM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [SUM_W-1:0] word_i,
  output logic [SUM_W-1:0] sum_o
);

  logic [SUM_W-1:0] sum_q;
  logic [SUM_W-1:0] sum_d;
  logic             sum_ce;

  always_comb begin
    sum_d  = sum_q;
    sum_ce = 1'b0;
    if (clr) begin
      sum_d  = '0;
      sum_ce = 1'b1;
    end else if (add_en) begin
      sum_d  = sum_q + word_i;
      sum_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (sum_ce) begin
      sum_q <= sum_d;
    end
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/cfgimg_seq.sv
module cfgimg_seq
  import cfgimg_pkg::*;
#(
  parameter logic [15:0] SIGNATURE = 16'h1234
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              verify_i,
  input  logic [15:0]       sum_i,
  output logic              busy_o,
  output logic              fill_en,
  output logic              clr,
  output logic              add_en,
  output logic              chk_en,
  output logic [WIDX_W-1:0] word_idx,
  output logic              done_o,
  output logic              valid_o
);

  localparam logic [WIDX_W-1:0] LAST_VERIFY = WIDX_W'(WORDS - 1);
  localparam logic [WIDX_W-1:0] LAST_BUILD  = WIDX_W'(WORDS - 2);

  seq_state_t        state_q, state_d;
  logic [WIDX_W-1:0] idx_q, idx_d;
  logic              vfy_q, vfy_d;
  logic              done_q, done_d;
  logic              valid_q, valid_d;
  logic [WIDX_W-1:0] last_idx;

  assign last_idx = vfy_q ? LAST_VERIFY : LAST_BUILD;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    vfy_d   = vfy_q;
    valid_d = valid_q;
    fill_en = 1'b0;
    clr     = 1'b0;
    add_en  = 1'b0;
    chk_en  = 1'b0;
    done_d  = (state_q == ST_FINISH);
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          vfy_d   = verify_i;
          valid_d = 1'b0;
          idx_d   = '0;
          clr     = 1'b1;
          state_d = verify_i ? ST_SUM : ST_FILL;
        end
      end
      ST_FILL: begin
        fill_en = 1'b1;
        state_d = ST_SUM;
      end
      ST_SUM: begin
        add_en = 1'b1;
        idx_d  = idx_q + 1'b1;
        if (idx_q == last_idx) begin
          state_d = ST_FINISH;
        end
      end
      ST_FINISH: begin
        if (vfy_q) begin
          valid_d = (sum_i == SIGNATURE);
        end else begin
          chk_en = 1'b1;
        end
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      vfy_q   <= 1'b0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      vfy_q   <= vfy_d;
      done_q  <= done_d;
      valid_q <= valid_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign word_idx = idx_q;
  assign done_o   = done_q;
  assign valid_o  = valid_q;

endmodule

// File: rtl/cfgimg_image_gen.sv
module cfgimg_image_gen
  import cfgimg_pkg::*;
#(
  parameter logic [15:0] SIGNATURE   = 16'h1234,
  parameter logic [7:0]  P_SCSI_ID   = 8'd7,
  parameter logic [7:0]  P_TAG_CNT   = 8'd4,
  parameter logic [3:0]  P_OPT_FLAGS = 4'b0111,
  parameter logic [7:0]  P_BOOT_ID   = 8'd0,
  parameter logic [7:0]  P_BOOT_LUN  = 8'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       verify_i,
  input  logic       wr_en_i,
  input  logic [6:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [6:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       valid_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              fill_en, clr, add_en, chk_en;
  logic [WIDX_W-1:0] word_idx;
  logic [15:0]       word;
  logic [15:0]       sum;
  logic [15:0]       chk_val;
  logic              wr_ok;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign wr_ok   = wr_en_i && !busy_o;
  assign chk_val = SIGNATURE - sum;

  cfgimg_seq #(.SIGNATURE(SIGNATURE)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (start_i),
    .verify_i (verify_i),
    .sum_i    (sum),
    .busy_o   (busy_o),
    .fill_en  (fill_en),
    .clr      (clr),
    .add_en   (add_en),
    .chk_en   (chk_en),
    .word_idx (word_idx),
    .done_o   (done_o),
    .valid_o  (valid_o)
  );

  cfgimg_store #(
    .P_SCSI_ID  (P_SCSI_ID),
    .P_TAG_CNT  (P_TAG_CNT),
    .P_OPT_FLAGS(P_OPT_FLAGS),
    .P_BOOT_ID  (P_BOOT_ID),
    .P_BOOT_LUN (P_BOOT_LUN)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fill_en  (fill_en),
    .chk_en   (chk_en),
    .chk_val  (chk_val),
    .wr_en    (wr_ok),
    .wr_addr  (wr_addr_i),
    .wr_data  (wr_data_i),
    .word_idx (word_idx),
    .rd_addr  (rd_addr_i),
    .rd_data  (rd_data_o),
    .word_o   (word)
  );

  cfgimg_accum #(.SUM_W(16)) u_acc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (clr),
    .add_en (add_en),
    .word_i (word),
    .sum_o  (sum)
  );

endmodule

// File: rtl/cfgimg_checks.sv
module cfgimg_checks (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic done_o,
  input logic valid_o
);

  // R4: completion pulse lasts one cycle
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4: completion never overlaps a run
  a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R9: a new run starts with the verdict cleared
  a_r9_valid_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !valid_o);

  // R3: a verdict appears only together with completion
  a_r3_valid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> done_o);

  // R9: verdict is held while idle and not completing
  a_r9_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o) && !done_o) |-> $stable(valid_o));

endmodule

bind cfgimg_image_gen cfgimg_checks u_checks (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .valid_o (valid_o)
);

// File: tb/sim_cfgimg_image_gen.sv
`timescale 1ns/1ps
module sim_cfgimg_image_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, verify_i = 1'b0, wr_en_i = 1'b0;
  logic [6:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       busy_o, done_o, valid_o;

  int tests = 0, fails = 0;

  typedef struct { logic [6:0] addr; logic [7:0] exp; string req; } rd_item_t;
  rd_item_t   exp_q[$];
  logic [7:0] mdl [128];

  always #5 clk = ~clk;

  cfgimg_image_gen u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .verify_i(verify_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected reads and compares at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      rd_item_t it;
      it = exp_q.pop_front();
      tests++;
      if (rd_data_o !== it.exp) begin
        fails++;
        $display("FAIL %s: byte %0d got 0x%0h expected 0x%0h",
                 it.req, it.addr, rd_data_o, it.exp);
      end
    end
  end

  // driver: present an address and queue what must come back
  task automatic rd_expect(logic [6:0] a, logic [7:0] e, string req);
    rd_item_t it;
    @(posedge clk);
    rd_addr_i = a;
    it.addr = a; it.exp = e; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic check_image(string req_lo);
    for (int i = 0; i < 128; i++)
      rd_expect(7'(i), mdl[i], (i >= 126) ? "R2" : req_lo);
    drain();
  endtask

  task automatic wr(logic [6:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [15:0] model_sum(int nwords);
    logic [15:0] s = 16'h0;
    for (int w = 0; w < nwords; w++) s = s + {mdl[2*w+1], mdl[2*w]};
    return s;
  endfunction

  task automatic model_defaults();
    logic [15:0] c;
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    for (int i = 0; i < 32; i += 2) mdl[i] = 8'h57;
    mdl[64] = 8'd7; mdl[67] = 8'd4; mdl[68] = 8'h07;
    mdl[69] = 8'd0; mdl[70] = 8'd0;
    c = 16'h1234 - model_sum(63);
    mdl[126] = c[7:0]; mdl[127] = c[15:8];
  endtask

  // one run; optional disturbance 20 cycles into it
  task automatic run_op(bit vfy, bit disturb);
    int n = 0;
    int ndone = 0;
    @(negedge clk);
    start_i = 1'b1; verify_i = vfy;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check("R4 busy after start", busy_o, 1);
    while (n < 200) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (disturb && n == 20) begin
        start_i = 1'b1; verify_i = 1'b0;
        wr_en_i = 1'b1; wr_addr_i = 7'd20; wr_data_i = 8'hAA;
        rd_addr_i = 7'd64;
      end else if (disturb && n == 21) begin
        start_i = 1'b0; wr_en_i = 1'b0;
        check("R7 read during run", rd_data_o, mdl[64]);
      end
      if (done_o) break;
      if (n < 65) check("R4 busy held", busy_o, 1);
    end
    check("R4 done latency", n, 65);
    check("R4 not busy at done", busy_o, 0);
    for (int k = 0; k < 70; k++) begin
      @(negedge clk);
      if (done_o) ndone++;
      if (busy_o) ndone += 100;
    end
    check(disturb ? "R5 no second run" : "R4 single pulse", ndone, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] c;
    repeat (3) @(negedge clk);
    check("R8 busy reset", busy_o, 0);
    check("R8 done reset", done_o, 0);
    check("R8 valid reset", valid_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_expect(7'd0, 8'h00, "R8");
    rd_expect(7'd127, 8'h00, "R8");
    drain();

    // build from defaults
    model_defaults();
    run_op(1'b0, 1'b0);
    check("R9 build valid", valid_o, 0);
    check_image("R1");

    // verify the built image
    run_op(1'b1, 1'b0);
    check("R3 verify good", valid_o, 1);

    // write and restart during a verify run
    run_op(1'b1, 1'b1);
    check("R6 verify unaffected", valid_o, 1);
    rd_expect(7'd20, mdl[20], "R6");
    drain();

    // idle write, then reject corrupted image
    wr(7'd10, 8'h56);
    mdl[10] = 8'h56;
    rd_expect(7'd10, 8'h56, "R6");
    drain();
    run_op(1'b1, 1'b0);
    check("R3 verify corrupt", valid_o, 0);

    // externally loaded image whose sum wraps many times
    for (int i = 0; i < 126; i++) begin
      mdl[i] = 8'((i * 37 + 8'hC3) & 8'hFF);
      wr(7'(i), mdl[i]);
    end
    c = 16'h1234 - model_sum(63);
    mdl[126] = c[7:0]; mdl[127] = c[15:8];
    wr(7'd126, mdl[126]);
    wr(7'd127, mdl[127]);
    run_op(1'b1, 1'b0);
    check("R3 verify wrapped sum", valid_o, 1);

    // single-bit error in the stored check value
    mdl[127] = mdl[127] ^ 8'h01;
    wr(7'd127, mdl[127]);
    run_op(1'b1, 1'b0);
    check("R3 verify bad check byte", valid_o, 0);

    // rebuild restores defaults over the custom image
    model_defaults();
    run_op(1'b0, 1'b0);
    check("R9 cleared by build", valid_o, 0);
    check_image("R1");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule